// File: doc/BRIEF.md
# Outstanding Request Deadlock Watchdog

This block sits beside a memory request sequencer and watches its table of outstanding requests for one that has waited too long. Requests belong to one of two classes, read-class and write-class, and each class has its own set of slots. The sequencer strobes an allocate when it places a request in a slot and a free when that request completes. On each allocate the block stores the value of a free-running cycle counter as the slot's issue time.

The block does not compare ages on every cycle. A single countdown timer schedules a check, and in that check cycle every slot of both classes is compared in parallel against a fixed threshold. The timer is started by an allocation, but only while the unit is not draining. After each check it starts again if any slot is still occupied, and otherwise it goes idle. Each check also compares the sequencer's own count of outstanding requests with the number of occupied slots.

Two sticky flags report the results. One reports an expired request, together with its class and slot. The other reports a mismatch between the sequencer's count and the table.

Top module: `pend_req_watchdog`

## Requirements
- R1: After a synchronous active-low reset, every slot is empty, the timer is idle, and `chk_now`, `dl_flag`, `dl_wr`, `dl_idx` and `cons_err` are all 0.
- R2: An allocate stores the current `cycle_cnt` as the slot's issue time and marks the slot occupied. A free empties the slot. When an allocate and a free name the same slot in the same cycle, the allocate wins and the slot keeps the new issue time.
- R3: When the timer is idle, an allocate with `drain` low starts it at clock edge E. `chk_now` is then high for exactly the one cycle that ends at edge E+THRESH. Allocations made while the timer is running do not restart it.
- R4: At the edge that ends a check cycle, the timer restarts for another THRESH cycles if any slot is occupied after that edge's allocate and free are applied. Otherwise it goes idle and `chk_now` stays low until a later allocate starts it.
- R5: A slot is expired when it is occupied and its age, (`cycle_cnt` − issue time) modulo 2^TS_W, is at least THRESH. Expiry is evaluated only in a check cycle, for the slots of both classes, using the table state before that edge's updates. A slot whose age is THRESH−1 is not expired.
- R6: `dl_flag` is set at the end of a check cycle in which some slot is expired. At the same edge `dl_wr` (0 = read class, 1 = write class) and `dl_idx` record the winning slot. Read-class slots win over write-class slots, and within a class the lower index wins. The flag and both fields then hold until reset.
- R7: `cons_err` is set at the end of a check cycle in which `pend_cnt` differs from the number of occupied slots in both classes. It holds until reset.
- R8: While `drain` is high, an allocate does not start an idle timer. A running timer, or a restart after a check, is not affected by `drain`.
- R9: The age in R5 is computed correctly when `cycle_cnt` has wrapped past zero since the issue time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cycle_cnt | input | TS_W | Free-running cycle counter |
| drain | input | 1 | Unit is draining; blocks starting an idle timer |
| alloc_vld | input | 1 | Allocate strobe |
| alloc_wr | input | 1 | Class of the allocate (0 read, 1 write) |
| alloc_idx | input | IDX_W | Slot index of the allocate |
| free_vld | input | 1 | Free strobe |
| free_wr | input | 1 | Class of the free (0 read, 1 write) |
| free_idx | input | IDX_W | Slot index of the free |
| pend_cnt | input | CNT_W | Sequencer's count of outstanding requests |
| chk_now | output | 1 | High in a check cycle |
| dl_flag | output | 1 | Sticky deadlock flag |
| dl_wr | output | 1 | Class of the reported slot |
| dl_idx | output | IDX_W | Index of the reported slot |
| cons_err | output | 1 | Sticky count-mismatch flag |

## Verification
The bench targets these corner cases, each named with what a faulty design would do:
- A request that is still present at the first check has age exactly THRESH and must be reported. A design that used a strict comparison would miss it.
- A second request allocated one cycle after the timer started has age THRESH−1 at that check and must not be reported. Finding it only at the following check shows both that the timer restarted and that the boundary is correct.
- An allocate made while draining must not start the timer. A design that ignored `drain` would produce a check pulse and flag a deadlock early.
- When one slot is freed and reallocated in the same cycle, the slot must keep the new issue time. A design that let the free win would leave the table empty and never report the slot.
- Two expired requests of different classes must be resolved in favour of the read class. A design with the wrong priority would report the write-class slot.
- A request whose age spans the wrap of the cycle counter must still be reported on time.

// File: rtl/wdg_pkg.sv
// Shared definitions for the deadlock watchdog.
// Assumes nothing beyond the elaboration parameters of the top module.
package wdg_pkg;

    // Request class; the encoding equals the alloc_wr / free_wr / dl_wr bit.
    typedef enum logic {
        REQ_RD = 1'b0,
        REQ_WR = 1'b1
    } req_cls_e;

    // Width of an index into n slots, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wdg_slot_table.sv
// Slot table for one request class: an occupancy bit and an issue timestamp
// per slot. Assumes at most one allocate and one free per cycle; when both
// name the same slot the allocate wins. Also exports the occupancy the table
// will hold after this edge, which the check timer uses to decide on restart.
module wdg_slot_table #(
    parameter int NUM_SLOTS = 4,
    parameter int TS_W      = 8,
    parameter int IDX_W     = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [TS_W-1:0]                    cycle_cnt,
    input  logic                               alloc_en,
    input  logic [IDX_W-1:0]                   alloc_idx,
    input  logic                               free_en,
    input  logic [IDX_W-1:0]                   free_idx,
    output logic [NUM_SLOTS-1:0]               occ_o,
    output logic [NUM_SLOTS-1:0][TS_W-1:0]     ts_o,
    output logic [NUM_SLOTS-1:0]               occ_nxt_o
);

    logic [NUM_SLOTS-1:0]           occ_q;
    logic [NUM_SLOTS-1:0][TS_W-1:0] ts_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit_alloc;
        logic hit_free;

        // Decode which strobe addresses this slot.
        always_comb begin
            hit_alloc = alloc_en && (alloc_idx == IDX_W'(i));
            hit_free  = free_en  && (free_idx  == IDX_W'(i));
        end

        // Next occupancy: allocate has priority over free.
        always_comb begin
            if (hit_alloc) begin
                occ_nxt_o[i] = 1'b1;
            end else if (hit_free) begin
                occ_nxt_o[i] = 1'b0;
            end else begin
                occ_nxt_o[i] = occ_q[i];
            end
        end

        // Register occupancy and capture the issue time on allocate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_q[i] <= 1'b0;
                ts_q[i]  <= '0;
            end else begin
                occ_q[i] <= occ_nxt_o[i];
                if (hit_alloc) begin
                    ts_q[i] <= cycle_cnt;
                end
            end
        end
    end

    assign occ_o = occ_q;
    assign ts_o  = ts_q;

endmodule

// File: rtl/wdg_expiry_scan.sv
// Parallel age check for one class. Every slot computes its wrap-safe
// unsigned age against the cycle counter; the lowest-indexed expired slot
// is reported. Assumes THRESH is below 2**TS_W so the compare is meaningful.
module wdg_expiry_scan #(
    parameter int NUM_SLOTS = 4,
    parameter int TS_W      = 8,
    parameter int IDX_W     = 2,
    parameter int THRESH    = 6
) (
    input  logic [NUM_SLOTS-1:0]           occ_i,
    input  logic [NUM_SLOTS-1:0][TS_W-1:0] ts_i,
    input  logic [TS_W-1:0]                cycle_cnt,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               hit_idx_o
);

    localparam logic [TS_W-1:0] LIMIT = TS_W'(THRESH);

    logic [NUM_SLOTS-1:0] expired;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_age
        logic [TS_W-1:0] age;

        // Modular subtraction keeps the age correct across counter wrap.
        always_comb begin
            age        = cycle_cnt - ts_i[i];
            expired[i] = occ_i[i] && (age >= LIMIT);
        end
    end

    // Pick the lowest expired index by scanning downward.
    always_comb begin
        hit_o     = |expired;
        hit_idx_o = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (expired[i]) begin
                hit_idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/wdg_check_timer.sv
// Countdown that schedules periodic checks. start_i arms an idle timer;
// in the check cycle keep_i decides whether to run another period or go idle.
// Assumes THRESH >= 1; a THRESH of 1 checks on every cycle while armed.
module wdg_check_timer #(
    parameter int THRESH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic keep_i,
    output logic chk_o,
    output logic armed_o
);

    localparam int TW = (THRESH > 1) ? $clog2(THRESH) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(THRESH - 1);

    logic          armed_q;
    logic [TW-1:0] left_q;

    // A check happens when the armed count has run out.
    always_comb begin
        chk_o   = armed_q && (left_q == '0);
        armed_o = armed_q;
    end

    // Arm, count down, and restart or idle after each check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            left_q  <= '0;
        end else if (chk_o) begin
            armed_q <= keep_i;
            left_q  <= keep_i ? RELOAD : '0;
        end else if (armed_q) begin
            left_q  <= left_q - 1'b1;
        end else if (start_i) begin
            armed_q <= 1'b1;
            left_q  <= RELOAD;
        end
    end

endmodule

// File: rtl/pend_req_watchdog.sv
// Deadlock watchdog over a read-class and a write-class slot table.
// Keeps one issue timestamp per slot, runs a parallel age check every
// THRESH cycles while requests remain, and latches sticky deadlock and
// count-mismatch flags. Assumes NUM_SLOTS >= 1, 1 <= THRESH < 2**TS_W, and
// that the caller's cycle_cnt advances by one each clock.
module pend_req_watchdog
    import wdg_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int TS_W      = 8,
    parameter int THRESH    = 6,
    localparam int IDX_W    = idx_width(NUM_SLOTS),
    localparam int CNT_W    = $clog2(2 * NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  cycle_cnt,
    input  logic             drain,
    input  logic             alloc_vld,
    input  logic             alloc_wr,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             free_vld,
    input  logic             free_wr,
    input  logic [IDX_W-1:0] free_idx,
    input  logic [CNT_W-1:0] pend_cnt,
    output logic             chk_now,
    output logic             dl_flag,
    output logic             dl_wr,
    output logic [IDX_W-1:0] dl_idx,
    output logic             cons_err
);

    localparam int NCLS = 2;

    logic [NCLS-1:0]                          cls_alloc;
    logic [NCLS-1:0]                          cls_free;
    logic [NCLS-1:0][NUM_SLOTS-1:0]           occ;
    logic [NCLS-1:0][NUM_SLOTS-1:0]           occ_nxt;
    logic [NCLS-1:0][NUM_SLOTS-1:0][TS_W-1:0] ts;
    logic [NCLS-1:0]                          cls_hit;
    logic [NCLS-1:0][IDX_W-1:0]               cls_idx;

    logic             any_occ;
    logic             any_next;
    logic             armed;
    logic [CNT_W-1:0] occ_cnt;
    logic             dl_flag_q;
    logic             dl_wr_q;
    logic [IDX_W-1:0] dl_idx_q;
    logic             cons_err_q;
    logic             pick_hit;
    logic             pick_wr;
    logic [IDX_W-1:0] pick_idx;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        // Route the strobes to the table of the matching class.
        always_comb begin
            cls_alloc[c] = alloc_vld && (alloc_wr == req_cls_e'(c));
            cls_free[c]  = free_vld  && (free_wr  == req_cls_e'(c));
        end

        wdg_slot_table #(
            .NUM_SLOTS (NUM_SLOTS),
            .TS_W      (TS_W),
            .IDX_W     (IDX_W)
        ) u_table (
            .clk       (clk),
            .rst_n     (rst_n),
            .cycle_cnt (cycle_cnt),
            .alloc_en  (cls_alloc[c]),
            .alloc_idx (alloc_idx),
            .free_en   (cls_free[c]),
            .free_idx  (free_idx),
            .occ_o     (occ[c]),
            .ts_o      (ts[c]),
            .occ_nxt_o (occ_nxt[c])
        );

        wdg_expiry_scan #(
            .NUM_SLOTS (NUM_SLOTS),
            .TS_W      (TS_W),
            .IDX_W     (IDX_W),
            .THRESH    (THRESH)
        ) u_scan (
            .occ_i     (occ[c]),
            .ts_i      (ts[c]),
            .cycle_cnt (cycle_cnt),
            .hit_o     (cls_hit[c]),
            .hit_idx_o (cls_idx[c])
        );
    end

    // Occupancy summaries: now, after this edge, and the population count.
    always_comb begin
        any_occ  = |occ;
        any_next = |occ_nxt;
        occ_cnt  = '0;
        for (int c = 0; c < NCLS; c++) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                occ_cnt = occ_cnt + CNT_W'(occ[c][i]);
            end
        end
    end

    wdg_check_timer #(
        .THRESH  (THRESH)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (alloc_vld && !drain),
        .keep_i  (any_next),
        .chk_o   (chk_now),
        .armed_o (armed)
    );

    // Read class wins over write class when both hold an expired slot.
    always_comb begin
        pick_hit = |cls_hit;
        pick_wr  = !cls_hit[REQ_RD];
        pick_idx = cls_hit[REQ_RD] ? cls_idx[REQ_RD] : cls_idx[REQ_WR];
    end

    // Latch the first deadlock report and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_flag_q <= 1'b0;
            dl_wr_q   <= 1'b0;
            dl_idx_q  <= '0;
        end else if (chk_now && pick_hit && !dl_flag_q) begin
            dl_flag_q <= 1'b1;
            dl_wr_q   <= pick_wr;
            dl_idx_q  <= pick_idx;
        end
    end

    // Latch a mismatch between the caller's count and the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_err_q <= 1'b0;
        end else if (chk_now && (occ_cnt != pend_cnt)) begin
            cons_err_q <= 1'b1;
        end
    end

    assign dl_flag  = dl_flag_q;
    assign dl_wr    = dl_wr_q;
    assign dl_idx   = dl_idx_q;
    assign cons_err = cons_err_q;

endmodule

// Temporal checks on the watchdog, attached through bind below.
module wdg_watchdog_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             drain,
    input logic             alloc_vld,
    input logic             chk_now,
    input logic             armed,
    input logic             any_occ,
    input logic             any_next,
    input logic             dl_flag,
    input logic             dl_wr,
    input logic [IDX_W-1:0] dl_idx,
    input logic             cons_err
);

    // R6
    dl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dl_flag |=> (dl_flag && $stable(dl_wr) && $stable(dl_idx)));

    // R7
    cons_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cons_err |=> cons_err);

    // R5
    dl_at_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_flag) |-> ($past(chk_now) && $past(any_occ)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && (drain || !alloc_vld)) |=> !armed);

    // R4
    idle_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_now && !any_next) |=> !armed);

endmodule

bind pend_req_watchdog wdg_watchdog_chk #(
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drain     (drain),
    .alloc_vld (alloc_vld),
    .chk_now   (chk_now),
    .armed     (armed),
    .any_occ   (any_occ),
    .any_next  (any_next),
    .dl_flag   (dl_flag),
    .dl_wr     (dl_wr),
    .dl_idx    (dl_idx),
    .cons_err  (cons_err)
);

// File: tb/pend_req_watchdog_tb.sv
module pend_req_watchdog_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS     = 4;
    localparam int TSW    = 8;
    localparam int THR    = 6;
    localparam int IW     = 2;
    localparam int CW     = $clog2(2 * NS + 1);
    localparam int MASK   = (1 << TSW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TSW-1:0] cyc = '0;
    logic           drain = 1'b0;
    logic           alloc_vld = 1'b0;
    logic           alloc_wr = 1'b0;
    logic [IW-1:0]  alloc_idx = '0;
    logic           free_vld = 1'b0;
    logic           free_wr = 1'b0;
    logic [IW-1:0]  free_idx = '0;
    logic [CW-1:0]  pend_cnt = '0;
    logic           chk_now;
    logic           dl_flag;
    logic           dl_wr;
    logic [IW-1:0]  dl_idx;
    logic           cons_err;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int cnt_ofs = 0;
    int cycles = 0;

    // Behavioural reference state
    bit m_occ [2][NS];
    int m_ts  [2][NS];
    int chk_edge = -1;
    int ecount = 0;
    bit m_dl = 0;
    int m_cls = 0;
    int m_idx = 0;
    bit m_cons = 0;

    pend_req_watchdog #(.NUM_SLOTS(NS), .TS_W(TSW), .THRESH(THR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cycle_cnt(cyc), .drain(drain),
        .alloc_vld(alloc_vld), .alloc_wr(alloc_wr), .alloc_idx(alloc_idx),
        .free_vld(free_vld), .free_wr(free_wr), .free_idx(free_idx),
        .pend_cnt(pend_cnt), .chk_now(chk_now), .dl_flag(dl_flag),
        .dl_wr(dl_wr), .dl_idx(dl_idx), .cons_err(cons_err));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_count();
        int n = 0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < NS; i++)
                n += m_occ[c][i];
        return n;
    endfunction

    // Cycle counter advances at each edge
    always @(posedge clk) cyc <= cyc + 1'b1;

    // Reference model update at each edge
    always @(posedge clk) begin
        int k;
        bit any;
        bit found;
        k = ecount;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < NS; i++) begin
                    m_occ[c][i] = 0;
                    m_ts[c][i] = 0;
                end
            chk_edge = -1;
            m_dl = 0; m_cls = 0; m_idx = 0; m_cons = 0;
        end else begin
            if (chk_edge == k) begin
                if (model_count() != int'(pend_cnt)) m_cons = 1;
                found = 0;
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < NS; i++)
                        if (!m_dl && !found && m_occ[c][i] &&
                            (((int'(cyc) - m_ts[c][i]) & MASK) >= THR)) begin
                            found = 1; m_dl = 1; m_cls = c; m_idx = i;
                        end
            end
            if (free_vld) m_occ[free_wr][free_idx] = 0;
            if (alloc_vld) begin
                m_occ[alloc_wr][alloc_idx] = 1;
                m_ts[alloc_wr][alloc_idx] = int'(cyc);
            end
            any = (model_count() != 0);
            if (chk_edge == k) chk_edge = any ? k + THR : -1;
            else if (chk_edge < 0 && alloc_vld && !drain) chk_edge = k + THR;
        end
        ecount = ecount + 1;
    end

    // Compare every cycle away from the edge; drive the caller's count
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(chk_now == (chk_edge == ecount), "R3/R4 chk_now", chk_now, chk_edge == ecount);
            if (chk_now) pulses++;
            check(dl_flag == m_dl, "R5/R6 dl_flag", dl_flag, m_dl);
            if (m_dl) begin
                check(dl_wr == m_cls[0], "R6 dl_wr", dl_wr, m_cls);
                check(int'(dl_idx) == m_idx, "R6 dl_idx", dl_idx, m_idx);
            end
            check(cons_err == m_cons, "R7 cons_err", cons_err, m_cons);
        end
        pend_cnt <= CW'(model_count() + cnt_ofs);
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drain = 1'b0; alloc_vld = 1'b0; free_vld = 1'b0; cnt_ofs = 0;
        idle(2);
        rst_n = 1'b1;
        pulses = 0;
    endtask

    task automatic alloc(input bit wr, input int idx);
        alloc_vld = 1'b1; alloc_wr = wr; alloc_idx = IW'(idx);
        idle(1);
        alloc_vld = 1'b0;
    endtask

    task automatic release_slot(input bit wr, input int idx);
        free_vld = 1'b1; free_wr = wr; free_idx = IW'(idx);
        idle(1);
        free_vld = 1'b0;
    endtask

    initial begin
        do_reset();
        idle(1);
        // R1 reset state
        check(!chk_now && !dl_flag && !dl_wr && dl_idx == 0 && !cons_err,
              "R1 reset outputs", {chk_now, dl_flag, dl_wr, cons_err}, 0);

        // R4: request freed before the check -> one check, then idle
        alloc(0, 0);
        idle(2);
        release_slot(0, 0);
        idle(15);
        check(pulses == 1, "R4 single check then idle", pulses, 1);
        check(!dl_flag, "R4 no deadlock", dl_flag, 0);

        // R8: allocate while draining does not start the timer
        do_reset();
        drain = 1'b1;
        alloc(1, 1);
        idle(15);
        check(pulses == 0, "R8 drain blocks arming", pulses, 0);
        check(!dl_flag, "R8 no flag while idle", dl_flag, 0);
        drain = 1'b0;
        alloc(1, 2);
        idle(THR + 2);
        check(dl_flag && dl_wr && dl_idx == 1, "R6 lowest write index", dl_idx, 1);

        // R5 boundary and R4 restart: second request has age THRESH-1 at first check
        do_reset();
        alloc(0, 2);
        alloc(0, 1);
        release_slot(0, 2);
        idle(THR - 2);
        check(pulses == 1 && !dl_flag, "R5 age THRESH-1 not expired", dl_flag, 0);
        idle(THR);
        check(dl_flag && !dl_wr && dl_idx == 1, "R4 restart finds slot 1", dl_idx, 1);

        // R6: read class wins over write class
        do_reset();
        drain = 1'b1;
        alloc(1, 0);
        drain = 1'b0;
        alloc(0, 3);
        idle(THR + 1);
        check(dl_flag && !dl_wr && dl_idx == 3, "R6 read class priority", dl_wr, 0);

        // R2: same-slot allocate and free in one cycle, allocate wins
        do_reset();
        alloc(0, 0);
        idle(2);
        alloc_vld = 1'b1; alloc_wr = 1'b0; alloc_idx = 0;
        free_vld = 1'b1; free_wr = 1'b0; free_idx = 0;
        idle(1);
        alloc_vld = 1'b0; free_vld = 1'b0;
        idle(THR);
        check(pulses == 1 && !dl_flag, "R2 new issue time kept", dl_flag, 0);
        idle(THR);
        check(dl_flag && dl_idx == 0, "R2 reallocated slot expires", dl_flag, 1);

        // R7: caller count off by one
        do_reset();
        cnt_ofs = 1;
        alloc(0, 1);
        idle(THR + 1);
        check(cons_err, "R7 count mismatch flagged", cons_err, 1);
        cnt_ofs = 0;
        idle(3);
        check(cons_err, "R7 mismatch sticky", cons_err, 1);

        // R9: issue time just before counter wrap
        do_reset();
        while (cyc != 8'd252) idle(1);
        alloc(0, 0);
        idle(THR + 1);
        check(dl_flag && !dl_wr && dl_idx == 0, "R9 wrap-safe age", dl_flag, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule